// File: doc/BRIEF.md
# Writeback Trap and Debug Entry Arbiter

This block decides, once per cycle, what happens to the instruction in the writeback stage of an in-order pipeline. The choices are: retire it normally, replace it with a non-maskable interrupt, replace it with a maskable interrupt, or divert it into debug mode because it requested debug entry (a breakpoint instruction, for example). On any trap or debug entry it raises a flush that kills every younger stage in the same cycle. It also reports the trap address, the saved return address and the interrupt number. It keeps its own copy of the global interrupt enable and the previous-enable bit, which a return-from-trap or a status write changes.

Re-enabling interrupts needs special care. Normally a debug request from the writeback instruction outranks a maskable interrupt. Once an interrupt return or a status write turns the global enable on, the block opens a short guard window. Inside that window the next instruction may not retire and may not enter debug. A pending, locally enabled interrupt therefore wins first, and the saved return address points at the cancelled instruction so that it can run again after the handler. In the same window, and in the cycle of the re-enable, a load or store in the execute stage is held back from issuing.

Top module: `wb_trap_arbiter`

## Requirements
- R1: After synchronous reset the global enable and the previous-enable bit are 0 and no guard window is open. With no valid writeback instruction, `act_o` is 0 (none) and `stall_o` is 0.
- R2: `act_o` encoding is 0 none, 1 retire, 2 maskable interrupt, 3 non-maskable interrupt, 4 debug entry. All traps and debug entries need `wb_valid_i`. `flush_o` is 1 exactly for codes 2, 3 and 4, and `epc_o` then equals `wb_pc_i`; otherwise `epc_o` is 0.
- R3: A retiring return-from-trap (`wb_mret_i`) copies the previous-enable bit into the global enable and sets the previous-enable bit to 1. A retiring status write (`wb_csr_we_i`) loads both bits from `wb_csr_gie_i` and `wb_csr_pie_i`.
- R4: When either event of R3 turns the global enable from 0 to 1, a guard window of GUARD_CYCLES cycles (default 1) opens in the following cycle. Inside it, `stall_o` is 1 unless an interrupt is taken, and the writeback instruction neither retires nor enters debug.
- R5: An interrupt that is pending, locally enabled and globally enabled during the guard window is taken (code 2) even when the writeback instruction is a breakpoint.
- R6: If no interrupt is takeable, the guard window closes after GUARD_CYCLES cycles and a waiting breakpoint then enters debug (code 4) at DBG_ADDR.
- R7: Outside a guard window, a debug request outranks a takeable maskable interrupt.
- R8: A non-maskable interrupt (`nmi_i`) with a valid writeback instruction always wins (code 3), with target NMI_ADDR, even inside a guard window.
- R9: Among the takeable interrupts, the lowest index wins. `cause_o` carries that index. The vectored target is `tvec_base_i + 4*index` (index 3 with base 0 gives 0xC). An interrupt whose local enable bit is 0 is ignored.
- R10: Taking a maskable or non-maskable interrupt copies the global enable into the previous-enable bit and clears the global enable.
- R11: `lsu_block_o` is 1 when `ex_lsu_i` is 1 and either a re-enable happens in the current cycle or a guard window is open; otherwise it is 0.
- R12: A status write that leaves an already set global enable at 1 opens no guard window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_pend_i | input | NIRQ | Pending interrupt lines |
| irq_en_i | input | NIRQ | Local per-interrupt enables |
| nmi_i | input | 1 | Non-maskable interrupt request |
| tvec_base_i | input | XLEN | Trap vector base address |
| wb_valid_i | input | 1 | Valid instruction in writeback |
| wb_pc_i | input | XLEN | Address of the writeback instruction |
| wb_ebreak_i | input | 1 | Writeback instruction requests debug entry |
| wb_mret_i | input | 1 | Writeback instruction is a return-from-trap |
| wb_csr_we_i | input | 1 | Writeback instruction writes the status enables |
| wb_csr_gie_i | input | 1 | Written global enable value |
| wb_csr_pie_i | input | 1 | Written previous-enable value |
| ex_lsu_i | input | 1 | Execute stage holds a load or store |
| act_o | output | 3 | Selected action (encoding in R2) |
| flush_o | output | 1 | Kill all younger stages |
| stall_o | output | 1 | Guard window holds writeback |
| lsu_block_o | output | 1 | Hold back the execute-stage memory access |
| target_o | output | XLEN | Redirect address for a trap or debug entry |
| epc_o | output | XLEN | Return address saved on a trap |
| cause_o | output | $clog2(NIRQ) | Index of the taken interrupt |
| gie_o | output | 1 | Current global interrupt enable |

## Verification
The hardest case to reach from the ports is the race between a freshly unmasked interrupt and a breakpoint directly behind the return-from-trap. The stimulus first writes the status bits so that the previous-enable bit is 1 and the global enable is 0. It then retires a return-from-trap while interrupt 3 is already pending and locally enabled. In the very next cycle it presents a breakpoint at 0x5fea. The same sequence is repeated with nothing pending, to show the one-cycle stall followed by debug entry, and with a non-maskable interrupt arriving inside the window. Loads and stores are offered in the execute stage across these cycles to observe the block signal.

// File: rtl/wbarb_pkg.sv
package wbarb_pkg;
  typedef enum logic [2:0] {
    ACT_NONE   = 3'd0,
    ACT_RETIRE = 3'd1,
    ACT_IRQ    = 3'd2,
    ACT_NMI    = 3'd3,
    ACT_DBG    = 3'd4
  } act_e;
endpackage

// File: rtl/irq_pick.sv
module irq_pick #(
  parameter int N  = 16,
  parameter int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N-1:0]  req_i,
  output logic          vld_o,
  output logic [IW-1:0] idx_o
);
  // lowest index has the highest priority
  always_comb begin
    vld_o = 1'b0;
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        vld_o = 1'b1;
        idx_o = IW'(i);
      end
    end
  end

  logic [N-1:0] below_mask;
  always_comb below_mask = (N'(1) << idx_o) - N'(1);

  // R9
  pick_is_lowest_chk: assert property (@(posedge clk) disable iff (rst)
    vld_o |-> (req_i[idx_o] && ((req_i & below_mask) == '0)));
  // R9
  pick_none_chk: assert property (@(posedge clk) disable iff (rst)
    (req_i == '0) |-> !vld_o);
endmodule

// File: rtl/status_track.sv
module status_track #(
  parameter int GUARD_CYCLES = 1,
  parameter int GW = $clog2(GUARD_CYCLES + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic mret_ev_i,
  input  logic csr_ev_i,
  input  logic csr_gie_i,
  input  logic csr_pie_i,
  input  logic trap_ev_i,
  output logic gie_o,
  output logic pie_o,
  output logic guard_o,
  output logic reen_o
);
  logic [GW-1:0] guard_cnt;

  always_comb reen_o = !gie_o && ((mret_ev_i && pie_o) || (csr_ev_i && csr_gie_i));
  always_comb guard_o = (guard_cnt != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      gie_o <= 1'b0;
      pie_o <= 1'b0;
    end else if (trap_ev_i) begin
      pie_o <= gie_o;
      gie_o <= 1'b0;
    end else if (mret_ev_i) begin
      gie_o <= pie_o;
      pie_o <= 1'b1;
    end else if (csr_ev_i) begin
      gie_o <= csr_gie_i;
      pie_o <= csr_pie_i;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)            guard_cnt <= '0;
    else if (trap_ev_i) guard_cnt <= '0;
    else if (reen_o)    guard_cnt <= GW'(GUARD_CYCLES);
    else if (guard_o)   guard_cnt <= guard_cnt - GW'(1);
  end

  // R4
  guard_opens_chk: assert property (@(posedge clk) disable iff (rst)
    (reen_o && !trap_ev_i) |=> (guard_o && gie_o));
  // R10
  trap_masks_chk: assert property (@(posedge clk) disable iff (rst)
    trap_ev_i |=> (!gie_o && !guard_o));
  // R12
  no_false_guard_chk: assert property (@(posedge clk) disable iff (rst)
    (gie_o && !trap_ev_i && !mret_ev_i && !guard_o) |=> !guard_o);
endmodule

// File: rtl/trap_vec.sv
module trap_vec #(
  parameter int          XLEN     = 32,
  parameter int          IW       = 4,
  parameter bit          VECTORED = 1'b1,
  parameter logic [31:0] NMI_ADDR = 32'h0000_0100,
  parameter logic [31:0] DBG_ADDR = 32'h0000_0800
) (
  input  wbarb_pkg::act_e  act_i,
  input  logic [IW-1:0]    idx_i,
  input  logic [XLEN-1:0]  base_i,
  output logic [XLEN-1:0]  target_o
);
  import wbarb_pkg::*;
  logic [XLEN-1:0] irq_addr;

  generate
    if (VECTORED) begin : g_vec
      always_comb irq_addr = base_i + (XLEN'(idx_i) << 2);
    end else begin : g_direct
      always_comb irq_addr = base_i;
    end
  endgenerate

  always_comb begin
    unique case (act_i)
      ACT_IRQ: target_o = irq_addr;
      ACT_NMI: target_o = XLEN'(NMI_ADDR);
      ACT_DBG: target_o = XLEN'(DBG_ADDR);
      default: target_o = '0;
    endcase
  end
endmodule

// File: rtl/wb_trap_arbiter.sv
module wb_trap_arbiter #(
  parameter int          XLEN         = 32,
  parameter int          NIRQ         = 16,
  parameter int          GUARD_CYCLES = 1,
  parameter bit          VECTORED     = 1'b1,
  parameter logic [31:0] NMI_ADDR     = 32'h0000_0100,
  parameter logic [31:0] DBG_ADDR     = 32'h0000_0800,
  localparam int         IW           = (NIRQ > 1) ? $clog2(NIRQ) : 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NIRQ-1:0] irq_pend_i,
  input  logic [NIRQ-1:0] irq_en_i,
  input  logic            nmi_i,
  input  logic [XLEN-1:0] tvec_base_i,
  input  logic            wb_valid_i,
  input  logic [XLEN-1:0] wb_pc_i,
  input  logic            wb_ebreak_i,
  input  logic            wb_mret_i,
  input  logic            wb_csr_we_i,
  input  logic            wb_csr_gie_i,
  input  logic            wb_csr_pie_i,
  input  logic            ex_lsu_i,
  output logic [2:0]      act_o,
  output logic            flush_o,
  output logic            stall_o,
  output logic            lsu_block_o,
  output logic [XLEN-1:0] target_o,
  output logic [XLEN-1:0] epc_o,
  output logic [IW-1:0]   cause_o,
  output logic            gie_o
);
  import wbarb_pkg::*;

  act_e          act;
  logic          irq_vld, takeable;
  logic [IW-1:0] irq_idx;
  logic          gie, pie, guard, reen;
  logic          retire, trap_ev;

  irq_pick #(.N(NIRQ), .IW(IW)) u_pick (
    .clk(clk), .rst(rst), .req_i(irq_pend_i & irq_en_i),
    .vld_o(irq_vld), .idx_o(irq_idx)
  );

  always_comb takeable = gie && irq_vld;

  // priority: NMI, then guard window, then debug, then maskable interrupt
  always_comb begin
    act = ACT_NONE;
    if (wb_valid_i) begin
      if (nmi_i)            act = ACT_NMI;
      else if (guard)       act = takeable ? ACT_IRQ : ACT_NONE;
      else if (wb_ebreak_i) act = ACT_DBG;
      else if (takeable)    act = ACT_IRQ;
      else                  act = ACT_RETIRE;
    end
  end

  always_comb retire  = (act == ACT_RETIRE);
  always_comb trap_ev = (act == ACT_IRQ) || (act == ACT_NMI);

  status_track #(.GUARD_CYCLES(GUARD_CYCLES)) u_stat (
    .clk(clk), .rst(rst),
    .mret_ev_i(retire && wb_mret_i),
    .csr_ev_i(retire && wb_csr_we_i),
    .csr_gie_i(wb_csr_gie_i), .csr_pie_i(wb_csr_pie_i),
    .trap_ev_i(trap_ev),
    .gie_o(gie), .pie_o(pie), .guard_o(guard), .reen_o(reen)
  );

  trap_vec #(.XLEN(XLEN), .IW(IW), .VECTORED(VECTORED),
             .NMI_ADDR(NMI_ADDR), .DBG_ADDR(DBG_ADDR)) u_vec (
    .act_i(act), .idx_i(irq_idx), .base_i(tvec_base_i), .target_o(target_o)
  );

  always_comb begin
    act_o       = act;
    flush_o     = trap_ev || (act == ACT_DBG);
    stall_o     = guard && !trap_ev;
    lsu_block_o = ex_lsu_i && (guard || reen);
    epc_o       = flush_o ? wb_pc_i : '0;
    cause_o     = (act == ACT_IRQ) ? irq_idx : '0;
    gie_o       = gie;
  end

  // R5
  guard_blocks_commit_chk: assert property (@(posedge clk) disable iff (rst)
    guard |-> (act != ACT_RETIRE && act != ACT_DBG));
  // R8
  nmi_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (wb_valid_i && nmi_i) |-> (act_o == 3'd3 && flush_o));
  // R11
  lsu_held_chk: assert property (@(posedge clk) disable iff (rst)
    (ex_lsu_i && guard) |-> lsu_block_o);
  // R2
  no_commit_without_valid_chk: assert property (@(posedge clk) disable iff (rst)
    !wb_valid_i |-> (!flush_o && act_o == 3'd0));
  // R4
  mret_reenable_chk: assert property (@(posedge clk) disable iff (rst)
    (retire && wb_mret_i && !gie && pie) |=> (stall_o || trap_ev));
endmodule

// File: tb/tb_wb_trap_arbiter.sv
module tb_wb_trap_arbiter;
  localparam int XLEN = 32;
  localparam int NIRQ = 16;
  localparam int IW   = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NIRQ-1:0] irq_pend, irq_en;
  logic nmi, wb_valid, wb_ebreak, wb_mret, csr_we, csr_gie, csr_pie, ex_lsu;
  logic [XLEN-1:0] tvec_base, wb_pc;
  logic [2:0] act;
  logic flush, stall, lsu_block, gie;
  logic [XLEN-1:0] target, epc;
  logic [IW-1:0] cause;

  always #4 clk = ~clk;  // 125 MHz

  wb_trap_arbiter dut (
    .clk(clk), .rst(rst), .irq_pend_i(irq_pend), .irq_en_i(irq_en), .nmi_i(nmi),
    .tvec_base_i(tvec_base), .wb_valid_i(wb_valid), .wb_pc_i(wb_pc),
    .wb_ebreak_i(wb_ebreak), .wb_mret_i(wb_mret), .wb_csr_we_i(csr_we),
    .wb_csr_gie_i(csr_gie), .wb_csr_pie_i(csr_pie), .ex_lsu_i(ex_lsu),
    .act_o(act), .flush_o(flush), .stall_o(stall), .lsu_block_o(lsu_block),
    .target_o(target), .epc_o(epc), .cause_o(cause), .gie_o(gie)
  );

  typedef struct {
    string       tag;
    logic [2:0]  act;
    logic        flush, stall, lsub, gie;
    logic [31:0] target, epc;
    logic [3:0]  cause;
  } exp_t;

  exp_t sb[$];
  int   n_run = 0, n_fail = 0;
  event smp_ev;
  bit   done = 1'b0;

  task automatic clear_in();
    irq_pend = '0; irq_en = '0; nmi = 0; tvec_base = '0; wb_valid = 0; wb_pc = '0;
    wb_ebreak = 0; wb_mret = 0; csr_we = 0; csr_gie = 0; csr_pie = 0; ex_lsu = 0;
  endtask

  // inputs are set by the caller after a negedge; this pushes the expectation
  task automatic expect_now(string tag, logic [2:0] a, logic st, logic lb,
                            logic [31:0] tg, logic [31:0] ep, logic [3:0] c, logic g);
    exp_t e;
    e.tag = tag; e.act = a; e.flush = (a >= 3'd2); e.stall = st; e.lsub = lb;
    e.target = tg; e.epc = ep; e.cause = c; e.gie = g;
    sb.push_back(e);
    #2;
    ->smp_ev;
    #1;
  endtask

  initial begin : monitor
    forever begin
      @(smp_ev);
      if (sb.size() != 0) begin
        exp_t e;
        e = sb.pop_front();
        n_run++;
        if (act !== e.act || flush !== e.flush || stall !== e.stall ||
            lsu_block !== e.lsub || target !== e.target || epc !== e.epc ||
            cause !== e.cause || gie !== e.gie) begin
          n_fail++;
          $display("FAIL %s: act=%0d flush=%0b stall=%0b lsub=%0b tgt=%h epc=%h cause=%0d gie=%0b | exp act=%0d flush=%0b stall=%0b lsub=%0b tgt=%h epc=%h cause=%0d gie=%0b",
                   e.tag, act, flush, stall, lsu_block, target, epc, cause, gie,
                   e.act, e.flush, e.stall, e.lsub, e.target, e.epc, e.cause, e.gie);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_fail++; n_run++;
      $display("FAIL watchdog: run did not finish");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin : driver
    clear_in();
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    // R1 reset state
    clear_in(); expect_now("R1", 3'd0, 0, 0, 0, 0, 0, 0);

    // R3 status write: gie=0 pie=1
    @(negedge clk); clear_in(); wb_valid = 1; wb_pc = 32'h40; csr_we = 1; csr_pie = 1;
    expect_now("R3", 3'd1, 0, 0, 0, 0, 0, 0);
    // R11 mret re-enables with irq 3 pending; load in execute blocked
    @(negedge clk); clear_in(); wb_valid = 1; wb_pc = 32'h44; wb_mret = 1;
    irq_pend = 16'h0008; irq_en = 16'h0008; ex_lsu = 1;
    expect_now("R11", 3'd1, 0, 1, 0, 0, 0, 0);
    // R5 breakpoint behind mret loses to irq 3, target 0xC
    @(negedge clk); clear_in(); wb_valid = 1; wb_pc = 32'h5fea; wb_ebreak = 1;
    irq_pend = 16'h0008; irq_en = 16'h0008; ex_lsu = 1;
    expect_now("R5", 3'd2, 0, 1, 32'hC, 32'h5fea, 4'd3, 1);
    // R10 global enable cleared after trap; R11 no block outside window
    @(negedge clk); clear_in(); irq_pend = 16'h0008; irq_en = 16'h0008; ex_lsu = 1;
    expect_now("R10", 3'd0, 0, 0, 0, 0, 0, 0);

    // R6 mret re-enable with nothing pending
    @(negedge clk); clear_in(); wb_valid = 1; wb_pc = 32'h50; wb_mret = 1;
    expect_now("R3", 3'd1, 0, 0, 0, 0, 0, 0);
    @(negedge clk); clear_in(); wb_valid = 1; wb_pc = 32'h5fea; wb_ebreak = 1;
    expect_now("R6", 3'd0, 1, 0, 0, 0, 0, 1);
    @(negedge clk); clear_in(); wb_valid = 1; wb_pc = 32'h5fea; wb_ebreak = 1;
    expect_now("R6", 3'd4, 0, 0, 32'h800, 32'h5fea, 0, 1);
    // R7 debug beats an already enabled irq
    @(negedge clk); clear_in(); wb_valid = 1; wb_pc = 32'h5fea; wb_ebreak = 1;
    irq_pend = 16'h0008; irq_en = 16'h0008;
    expect_now("R7", 3'd4, 0, 0, 32'h800, 32'h5fea, 0, 1);
    // R9 lowest enabled index wins: bits 5 and 9
    @(negedge clk); clear_in(); wb_valid = 1; wb_pc = 32'h60; tvec_base = 32'h0;
    irq_pend = 16'h0220; irq_en = 16'h0220;
    expect_now("R9", 3'd2, 0, 0, 32'h14, 32'h60, 4'd5, 1);

    // R8 status write re-enables, NMI in the window beats irq
    @(negedge clk); clear_in(); wb_valid = 1; wb_pc = 32'h6c; csr_we = 1; csr_gie = 1;
    irq_pend = 16'h0220; irq_en = 16'h0200;
    expect_now("R4", 3'd1, 0, 0, 0, 0, 0, 0);
    @(negedge clk); clear_in(); wb_valid = 1; wb_pc = 32'h70; nmi = 1;
    irq_pend = 16'h0220; irq_en = 16'h0200;
    expect_now("R8", 3'd3, 0, 0, 32'h100, 32'h70, 0, 1);
    @(negedge clk); clear_in();
    expect_now("R10", 3'd0, 0, 0, 0, 0, 0, 0);

    // R9 locally disabled irq ignored; R4 window with empty writeback
    @(negedge clk); clear_in(); wb_valid = 1; wb_pc = 32'h78; csr_we = 1; csr_gie = 1;
    irq_pend = 16'h0008;
    expect_now("R4", 3'd1, 0, 0, 0, 0, 0, 0);
    @(negedge clk); clear_in(); irq_pend = 16'h0008;
    expect_now("R4", 3'd0, 1, 0, 0, 0, 0, 1);
    @(negedge clk); clear_in(); wb_valid = 1; wb_pc = 32'h80; irq_pend = 16'h0008;
    expect_now("R9", 3'd1, 0, 0, 0, 0, 0, 1);
    // R12 write keeping gie=1 opens no window
    @(negedge clk); clear_in(); wb_valid = 1; wb_pc = 32'h84; csr_we = 1; csr_gie = 1;
    ex_lsu = 1;
    expect_now("R12", 3'd1, 0, 0, 0, 0, 0, 1);
    @(negedge clk); clear_in(); wb_valid = 1; wb_pc = 32'h88; wb_ebreak = 1; ex_lsu = 1;
    expect_now("R12", 3'd4, 0, 0, 32'h800, 32'h88, 0, 1);
    // R2 plain retire: no flush, epc 0
    @(negedge clk); clear_in(); wb_valid = 1; wb_pc = 32'h8c;
    expect_now("R2", 3'd1, 0, 0, 0, 0, 0, 1);

    @(negedge clk);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule